// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a two-level page table held in memory. A requester, usually the logic behind a missed translation cache lookup, hands it a virtual address. The walker then reads a first-level (directory) entry. If that entry is marked present, it reads a second-level entry. It returns either the physical frame with its permission bits or a fault that names the level at which the walk stopped. The low 12 bits of the address are the byte offset within a 4 KB page and pass through unchanged.

The base of the directory comes from a plain root input. The root is sampled only when a request is accepted, so software may change it while a walk is in progress without disturbing that walk. The table base held in any entry is that entry with its low 12 bits cleared. An entry's address is its table base plus four times its 10-bit index.

All three data interfaces use valid/ready or valid-only handshakes:
- **Request input.** `req_ready` is high only while the walker is idle. It drops when a request is accepted and does not rise again until the requester has taken the result.
- **Memory read request.** Once `mem_req_valid` is raised, it and its address stay fixed until `mem_req_ready` is seen.
- **Memory response.** The response has no back-pressure and may arrive after any number of cycles.
- **Result output.** `res_valid` and the result fields hold steady for as long as `res_ready` stays low.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, while `res_valid` and `mem_req_valid` are 0.
- R2: The first read of a walk goes to (root with bits 11:0 cleared) + 4 × vaddr[31:22], using the root value present on the accepting cycle.
- R3: After a directory entry with bit 0 = 1, the second read goes to (that entry with bits 11:0 cleared) + 4 × vaddr[21:12].
- R4: When the second-level entry has bit 0 = 1, the result has `res_fault` = 0, `res_pfn` = entry[31:12], `res_perm` = entry[11:0], and `res_paddr` = {entry[31:12], vaddr[11:0]}.
- R5: A directory entry with bit 0 = 0 ends the walk after exactly one read, with `res_fault` = 1, `res_fault_level` = 0, and `res_pfn`, `res_perm` and `res_paddr` all zero.
- R6: A second-level entry with bit 0 = 0 gives `res_fault` = 1, `res_fault_level` = 1, and `res_pfn`, `res_perm` and `res_paddr` all zero, after exactly two reads.
- R7: `req_ready` stays 0 from the cycle after a request is accepted until the cycle after the result is taken (`res_valid` and `res_ready` both 1), so only one walk is in flight at a time.
- R8: While `res_valid` = 1 and `res_ready` = 0, every result field holds its value.
- R9: While `mem_req_valid` = 1 and `mem_req_ready` = 0, the request stays valid with an unchanged address. Walks complete correctly for any ready stall and any response latency.
- R10: Changing `root_base` after acceptance has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Directory base; bits 11:0 ignored |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid, one cycle per read |
| mem_rsp_data | input | 32 | Entry returned by memory |
| res_valid | output | 1 | Result or fault available |
| res_ready | input | 1 | Requester takes the result |
| res_fault | output | 1 | Walk found a non-present entry |
| res_fault_level | output | 1 | 0 = directory, 1 = second level |
| res_paddr | output | 32 | Translated physical address |
| res_pfn | output | 20 | Physical frame number |
| res_perm | output | 12 | Low 12 bits of the second-level entry |

## Verification
The assertions take two things on trust from the memory side:
- exactly one `mem_rsp_valid` pulse follows each accepted read;
- no pulse arrives while no read is outstanding.

The bench's memory model keeps to this by holding a single pending slot that is loaded only on a request handshake and drives one response pulse after a set latency. The assertions also assume that the requester holds `res_ready` as it pleases while never dropping a request it has raised. The bench raises `req_valid` only while the walker is idle and holds it there until the request is accepted.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    S_IDLE      = 2'd0,
    S_DIR_WAIT  = 2'd1,
    S_LEAF_WAIT = 2'd2,
    S_DONE      = 2'd3
  } walk_state_e;

  localparam int LVL_DIR  = 0;
  localparam int LVL_LEAF = 1;
  localparam int N_LEVELS = 2;
endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int PTE_W = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic [VA_W-1:0]                          vaddr,
  input  logic [ptw_pkg::N_LEVELS-1:0][PTE_W-1:0] bases,
  output logic [ptw_pkg::N_LEVELS-1:0][PA_W-1:0]  entry_addr
);
  localparam int LEVELS      = ptw_pkg::N_LEVELS;
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);
  localparam logic [PA_W-1:0] BASE_MASK = {{(PA_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

  // one index field and one entry address per table level
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int HI = OFF_W + IDX_W * (LEVELS - lv) - 1;
    logic [IDX_W-1:0] idx;
    assign idx = vaddr[HI -: IDX_W];
    assign entry_addr[lv] = (PA_W'(bases[lv]) & BASE_MASK)
                          + (PA_W'(idx) << ENTRY_SHIFT);
  end
endmodule

// File: rtl/ptw_mem_port.sv
module ptw_mem_port #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [PA_W-1:0] issue_addr,
  input  logic            mem_req_ready,
  output logic            mem_req_valid,
  output logic [PA_W-1:0] mem_req_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else if (issue) begin
      mem_req_valid <= 1'b1;
      mem_req_addr  <= issue_addr;
    end else if (mem_req_valid && mem_req_ready) begin
      mem_req_valid <= 1'b0;
    end
  end

  // R9: a stalled read keeps its valid and its address
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R7: a new read is never issued over one still waiting
  a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !mem_req_valid);
endmodule

// File: rtl/ptw_result.sv
module ptw_result #(
  parameter int PA_W  = 32,
  parameter int PTE_W = 32,
  parameter int OFF_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 load_fault,
  input  logic                 load_level,
  input  logic [PTE_W-1:0]     load_entry,
  input  logic [OFF_W-1:0]     load_offset,
  input  logic                 res_ready,
  output logic                 res_valid,
  output logic                 res_fault,
  output logic                 res_fault_level,
  output logic [PA_W-1:0]      res_paddr,
  output logic [PA_W-OFF_W-1:0] res_pfn,
  output logic [OFF_W-1:0]     res_perm,
  output logic                 taken
);
  localparam int PFN_W = PA_W - OFF_W;

  logic [PFN_W-1:0] pfn_d;
  logic [OFF_W-1:0] perm_d;

  assign pfn_d  = load_fault ? '0 : load_entry[PA_W-1:OFF_W];
  assign perm_d = load_fault ? '0 : load_entry[OFF_W-1:0];
  assign taken  = res_valid && res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid       <= 1'b0;
      res_fault       <= 1'b0;
      res_fault_level <= 1'b0;
      res_paddr       <= '0;
      res_pfn         <= '0;
      res_perm        <= '0;
    end else if (load) begin
      res_valid       <= 1'b1;
      res_fault       <= load_fault;
      res_fault_level <= load_level;
      res_pfn         <= pfn_d;
      res_perm        <= perm_d;
      res_paddr       <= load_fault ? '0 : {pfn_d, load_offset};
    end else if (taken) begin
      res_valid       <= 1'b0;
    end
  end

  // R8: a result that is not yet taken holds all of its fields
  a_r8_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr) && $stable(res_fault)
      && $stable(res_fault_level) && $stable(res_perm)));

  // R4: a translation is reported only from an entry whose present bit is set
  a_r4_present_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault) |-> res_perm[0]);

  // R5 / R6: a fault carries no frame
  a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_pfn == '0 && res_paddr == '0));
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int PTE_W = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PA_W-1:0]       root_base,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [PA_W-1:0]       mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [PTE_W-1:0]      mem_rsp_data,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic                  res_fault,
  output logic                  res_fault_level,
  output logic [PA_W-1:0]       res_paddr,
  output logic [PA_W-OFF_W-1:0] res_pfn,
  output logic [OFF_W-1:0]      res_perm
);
  import ptw_pkg::*;

  walk_state_e state_q;
  logic [VA_W-1:0] vaddr_q;
  logic            accept;
  logic            rsp_take;
  logic            present;
  logic            issue;
  logic [PA_W-1:0] issue_addr;
  logic            res_load;
  logic            res_taken;
  logic [VA_W-1:0] vaddr_sel;
  logic [N_LEVELS-1:0][PTE_W-1:0] bases;
  logic [N_LEVELS-1:0][PA_W-1:0]  entry_addr;

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_ready && req_valid;
  assign present   = mem_rsp_data[0];
  assign rsp_take  = mem_rsp_valid && !mem_req_valid
                   && (state_q == S_DIR_WAIT || state_q == S_LEAF_WAIT);

  // the root and the address are taken from the ports only on the accepting cycle
  assign vaddr_sel        = (state_q == S_IDLE) ? req_vaddr : vaddr_q;
  assign bases[LVL_DIR]   = PTE_W'(root_base);
  assign bases[LVL_LEAF]  = mem_rsp_data;

  ptw_index #(
    .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) u_index (
    .vaddr      (vaddr_sel),
    .bases      (bases),
    .entry_addr (entry_addr)
  );

  assign issue      = accept || (state_q == S_DIR_WAIT && rsp_take && present);
  assign issue_addr = (state_q == S_IDLE) ? entry_addr[LVL_DIR] : entry_addr[LVL_LEAF];
  assign res_load   = rsp_take && (state_q == S_LEAF_WAIT || !present);

  ptw_mem_port #(.PA_W(PA_W)) u_mem (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue         (issue),
    .issue_addr    (issue_addr),
    .mem_req_ready (mem_req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr)
  );

  ptw_result #(.PA_W(PA_W), .PTE_W(PTE_W), .OFF_W(OFF_W)) u_res (
    .clk             (clk),
    .rst_n           (rst_n),
    .load            (res_load),
    .load_fault      (!present),
    .load_level      (state_q == S_LEAF_WAIT),
    .load_entry      (mem_rsp_data),
    .load_offset     (vaddr_q[OFF_W-1:0]),
    .res_ready       (res_ready),
    .res_valid       (res_valid),
    .res_fault       (res_fault),
    .res_fault_level (res_fault_level),
    .res_paddr       (res_paddr),
    .res_pfn         (res_pfn),
    .res_perm        (res_perm),
    .taken           (res_taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      vaddr_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          state_q <= S_DIR_WAIT;
          vaddr_q <= req_vaddr;
        end
        S_DIR_WAIT: if (rsp_take) state_q <= present ? S_LEAF_WAIT : S_DONE;
        S_LEAF_WAIT: if (rsp_take) state_q <= S_DONE;
        S_DONE: if (res_taken) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R7: acceptance closes the request port
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7: a pending result keeps the request port closed
  a_r7_no_accept_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  // R1: an idle walker issues no memory traffic
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !res_valid));

  // R5: a directory fault does not start a second read
  a_r5_no_read_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault && !res_fault_level) |-> !mem_req_valid);
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] root_base;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        res_valid;
  logic        res_ready;
  logic        res_fault;
  logic        res_fault_level;
  logic [31:0] res_paddr;
  logic [19:0] res_pfn;
  logic [11:0] res_perm;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
    .res_fault_level(res_fault_level), .res_paddr(res_paddr), .res_pfn(res_pfn),
    .res_perm(res_perm)
  );

  // ---------------- memory model ----------------
  logic [31:0] pmem [logic [31:0]];
  int          lat_cfg   = 0;
  int          stall_cfg = 0;
  logic [31:0] addr_log [4];
  int          n_log = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (pmem.exists(a)) return pmem[a];
    return 32'h0;
  endfunction

  initial begin
    bit          pending = 0;
    int          cnt = 0;
    int          rcnt = 0;
    logic [31:0] pa = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(posedge clk);
      mem_rsp_valid <= 1'b0;
      if (pending) begin
        if (cnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= rd(pa);
          pending = 0;
        end else cnt--;
      end
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (n_log < 4) addr_log[n_log] = mem_req_addr;
        n_log++;
        pa = mem_req_addr;
        pending = 1;
        cnt = lat_cfg;
      end
      mem_req_ready <= (stall_cfg == 0) || ((rcnt % (stall_cfg + 1)) == stall_cfg);
      rcnt++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_addr(input logic [31:0] root, input logic [31:0] va);
    return {root[31:12], 12'h0} + {20'h0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] leaf_addr(input logic [31:0] ent, input logic [31:0] va);
    return {ent[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
  endfunction

  // one complete walk with checks of addresses, result and handshake
  task automatic do_walk(input logic [31:0] va, input logic [31:0] root, input bit change_root,
                         input bit exp_fault, input bit exp_lvl, input logic [31:0] exp_pa,
                         input logic [11:0] exp_perm, input int exp_reads,
                         input logic [31:0] exp_a0, input logic [31:0] exp_a1);
    int waitc = 0;
    logic [31:0] hold_pa;
    n_log = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; root_base = root;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 req_ready low after accept", {31'h0, req_ready}, 32'h0);
    if (change_root) root_base = ~root;
    while (!res_valid && waitc < 300) begin @(negedge clk); waitc++; end
    chk("R9 result arrives", {31'h0, res_valid}, 32'h1);
    chk("R7 req_ready low with result", {31'h0, req_ready}, 32'h0);
    chk(exp_fault ? (exp_lvl ? "R6 fault" : "R5 fault") : "R4 no fault", {31'h0, res_fault}, {31'h0, exp_fault});
    if (exp_fault) chk(exp_lvl ? "R6 level" : "R5 level", {31'h0, res_fault_level}, {31'h0, exp_lvl});
    chk(exp_fault ? "R5/R6 paddr zero" : "R4 paddr", res_paddr, exp_pa);
    chk(exp_fault ? "R5/R6 pfn zero" : "R4 pfn", {12'h0, res_pfn}, {12'h0, exp_pa[31:12]});
    chk(exp_fault ? "R5/R6 perm zero" : "R4 perm", {20'h0, res_perm}, {20'h0, exp_perm});
    chk(exp_lvl || !exp_fault ? "R6 read count" : "R5 read count", n_log, exp_reads);
    chk(change_root ? "R10 dir address" : "R2 dir address", addr_log[0], exp_a0);
    if (exp_reads > 1) chk("R3 leaf address", addr_log[1], exp_a1);
    // back-pressure on the result
    hold_pa = res_paddr;
    repeat (3) @(negedge clk);
    chk("R8 valid held", {31'h0, res_valid}, 32'h1);
    chk("R8 paddr held", res_paddr, hold_pa);
    chk("R7 still busy", {31'h0, req_ready}, 32'h0);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R7 ready after take", {31'h0, req_ready}, 32'h1);
    chk("R7 result cleared", {31'h0, res_valid}, 32'h0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; root_base = '0; res_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1 res_valid", {31'h0, res_valid}, 32'h0);
    chk("R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
  endtask

  task automatic t_map_basic();
    logic [31:0] va = 32'h0040_3ABC, root = 32'h0010_0000;
    logic [31:0] de = 32'h0020_0001, le = 32'h1234_5067;
    lat_cfg = 0; stall_cfg = 0;
    pmem[dir_addr(root, va)] = de;
    pmem[leaf_addr(de, va)]  = le;
    do_walk(va, root, 0, 0, 0, {le[31:12], va[11:0]}, le[11:0], 2,
            dir_addr(root, va), leaf_addr(de, va));
  endtask

  task automatic t_stall_latency();
    logic [31:0] va = 32'hFFFF_FFFF, root = 32'h0030_0ABC;
    logic [31:0] de = 32'h0040_0FFF, le = 32'hABCD_E003;
    lat_cfg = 5; stall_cfg = 3;
    pmem[dir_addr(root, va)] = de;
    pmem[leaf_addr(de, va)]  = le;
    do_walk(va, root, 0, 0, 0, {le[31:12], va[11:0]}, le[11:0], 2,
            dir_addr(root, va), leaf_addr(de, va));
  endtask

  task automatic t_dir_fault();
    logic [31:0] va = 32'h8000_0123, root = 32'h0010_0000;
    lat_cfg = 2; stall_cfg = 1;
    pmem[dir_addr(root, va)] = 32'h0050_0FFE;
    do_walk(va, root, 0, 1, 0, 32'h0, 12'h0, 1, dir_addr(root, va), 32'h0);
  endtask

  task automatic t_leaf_fault();
    logic [31:0] va = 32'h0040_5777, root = 32'h0010_0000;
    logic [31:0] de = 32'h0020_0001;
    lat_cfg = 1; stall_cfg = 0;
    pmem[leaf_addr(de, va)] = 32'h7777_7FFE;
    do_walk(va, root, 0, 1, 1, 32'h0, 12'h0, 2, dir_addr(root, va), leaf_addr(de, va));
  endtask

  task automatic t_root_change();
    logic [31:0] va = 32'h0C81_2345, root = 32'h0060_0000;
    logic [31:0] de = 32'h0070_0003, le = 32'h0BEE_F005;
    lat_cfg = 4; stall_cfg = 2;
    pmem[dir_addr(root, va)] = de;
    pmem[leaf_addr(de, va)]  = le;
    do_walk(va, root, 1, 0, 0, {le[31:12], va[11:0]}, le[11:0], 2,
            dir_addr(root, va), leaf_addr(de, va));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_map_basic();
    t_stall_latency();
    t_dir_fault();
    t_leaf_fault();
    t_root_change();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule